// File: doc/BRIEF.md
# Edge-Selectable Serial Command Receiver

This block is the slave end of a clock-synchronous serial link. A host sends 8-bit command bytes on a data line, clocked by a serial clock that the host owns, while an active-low select is held low. At the same time the block shifts a status byte back out on its own data line, most significant bit first. A polarity pin sets which serial clock edge captures incoming bits; outgoing bits change on the other edge. The serial inputs pass through a synchroniser and their edges are found in the system clock domain, so the system clock must run at least four times faster than the serial clock.

Each completed byte goes to a downstream decoder as a one-cycle strobe. The block then holds a busy flag low for a fixed number of cycles, and it drops any byte that completes during that window. To guard against noise on the link, a double-entry mode can be turned on. In that mode every byte is sent twice, and it is passed on only when both copies are equal. A mismatch sets an error flag that stays set until an error-clear byte is accepted. The block itself decodes only the two bytes that change its own behaviour: the power-up byte and the error-clear byte.

Top module: `sercmd_rx`

## Requirements
- R1: Bits are taken MSB first. On the 8th capture edge within one selection, `cmd_v_o` pulses high for exactly one cycle and `cmd_o` carries the byte.
- R2: With `pol_i` low, bits are captured on rising `sck_i` edges and `sdo_o` changes on falling edges. With `pol_i` high, both edges are swapped.
- R3: While `cs_n_i` is high, `sck_i` and `sdi_i` have no effect. Deselecting clears the bit count, so a byte that was cut short is discarded and the next selection starts a new byte.
- R4: `sdo_o` is high impedance while `cs_n_i` is high. While the block is selected, `sdo_o` drives `stat_i` MSB first. `stat_i` is loaded when the block is selected and loaded again after every 8 output edges.
- R5: In double-entry mode, a byte is strobed out only when the second copy equals the first. The first copy alone produces no strobe.
- R6: In double-entry mode, a mismatched pair sets `err_o` and strobes nothing. `err_o` stays high through later accepted bytes until an accepted byte equal to 0xFF clears it.
- R7: An accepted byte whose bits 7..1 are all zero is the power-up byte. Its bit 0 sets double-entry mode (1 = on, 0 = off) for the bytes that follow.
- R8: `busy_n_o` goes low in the same cycle as the strobe and stays low for BUSY_CYC cycles. A byte that completes while `busy_n_o` is low is dropped.
- R9: Deselecting clears a pending first copy. After the block is selected again, the next byte counts as a new first copy.
- R10: After reset, `err_o` is 0, `busy_n_o` is 1, `cmd_v_o` is 0, and double-entry mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low select from host |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in |
| pol_i | input | 1 | Edge polarity: 0 = capture on rising edge, 1 = capture on falling edge |
| stat_i | input | BYTE_W | Status byte to shift out |
| sdo_o | output | 1 | Serial data out, high impedance when deselected |
| cmd_v_o | output | 1 | One-cycle strobe for an accepted byte |
| cmd_o | output | BYTE_W | Accepted byte |
| err_o | output | 1 | Sticky mismatch error |
| busy_n_o | output | 1 | Low while a byte is being handed on |

## Verification
A wrong bit count would show up as a missing or misaligned byte at `cmd_o` on the very next transfer. This makes the cut-short-byte and deselect-while-idle cases sharp tests. A stale pending first copy, or a wrong mode bit, would show as an extra or missing strobe within the next one or two bytes. A wrong transmit register would corrupt the bits read back during the same transfer. A wrong busy counter would show as a second byte being accepted when it should be dropped, or as `busy_n_o` staying low too long.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int SYNC_DEF = 2;

  function automatic logic is_pup(input logic [7:0] b);
    return (b[7:1] == 7'd0);
  endfunction
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              pol_s,
  input  logic [BYTE_W-1:0] stat_i,
  output logic              byte_v_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              abort_o,
  output logic              sdo_d_o,
  output logic              sdo_oe_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic sck_q, cs_q;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;

  logic rise, fall, in_edge, out_edge, sel, cs_fall, cs_rise;
  assign rise     = sck_s & ~sck_q;
  assign fall     = ~sck_s & sck_q;
  assign in_edge  = pol_s ? fall : rise;
  assign out_edge = pol_s ? rise : fall;
  assign sel      = ~cs_n_s;
  assign cs_fall  = cs_q & ~cs_n_s;
  assign cs_rise  = ~cs_q & cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      abort_o <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      abort_o <= cs_rise;
    end
  end

  // receive path
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt   <= '0;
      rx_sr    <= '0;
      byte_v_o <= 1'b0;
      byte_o   <= '0;
    end else begin
      byte_v_o <= 1'b0;
      if (!sel) begin
        rx_cnt <= '0;
        rx_sr  <= '0;
      end else if (in_edge) begin
        rx_sr <= {rx_sr[BYTE_W-2:0], sdi_s};
        if (rx_cnt == LAST) begin
          rx_cnt   <= '0;
          byte_v_o <= 1'b1;
          byte_o   <= {rx_sr[BYTE_W-2:0], sdi_s};
        end else begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end
    end
  end

  // transmit path
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr    <= '0;
      tx_cnt   <= '0;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_oe_o <= sel;
      if (cs_fall) begin
        tx_sr  <= stat_i;
        tx_cnt <= '0;
      end else if (sel && out_edge) begin
        if (tx_cnt == LAST) begin
          tx_sr  <= stat_i;
          tx_cnt <= '0;
        end else begin
          tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  assign sdo_d_o = tx_sr[BYTE_W-1];

  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (rx_cnt == '0));

  p_strobe_edge_r1: assert property (@(posedge clk) disable iff (rst)
    byte_v_o |-> $past(in_edge && sel));

  p_hiz_desel_r4: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n_s) |-> !sdo_oe_o);
endmodule

// File: rtl/sercmd_filt.sv
module sercmd_filt #(
  parameter int BYTE_W = 8,
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_v_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              abort_i,
  output logic              cmd_v_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              err_o,
  output logic              busy_n_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BYTE_W-1:0] ERR_CLR = '1;

  logic dbl, have_first, busy_q;
  logic [BYTE_W-1:0] first;
  logic [BW-1:0] bcnt;
  logic take, acc, mism;

  assign take = byte_v_i & ~busy_q;

  always_comb begin
    acc  = 1'b0;
    mism = 1'b0;
    if (take) begin
      if (!dbl)                 acc  = 1'b1;
      else if (have_first) begin
        if (byte_i == first)    acc  = 1'b1;
        else                    mism = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbl <= 1'b0; have_first <= 1'b0; first <= '0;
      busy_q <= 1'b0; bcnt <= '0;
      cmd_v_o <= 1'b0; cmd_o <= '0; err_o <= 1'b0;
    end else begin
      cmd_v_o <= acc;
      if (take && dbl) begin
        have_first <= ~have_first;
        if (!have_first) first <= byte_i;
      end
      if (abort_i) have_first <= 1'b0;
      if (acc) begin
        cmd_o  <= byte_i;
        busy_q <= 1'b1;
        bcnt   <= BW'(BUSY_CYC - 1);
        if (byte_i[BYTE_W-1:1] == '0) dbl <= byte_i[0];
      end else if (busy_q) begin
        if (bcnt == '0) busy_q <= 1'b0;
        else            bcnt   <= bcnt - 1'b1;
      end
      if (mism)                          err_o <= 1'b1;
      else if (acc && byte_i == ERR_CLR) err_o <= 1'b0;
    end
  end

  assign busy_n_o = ~busy_q;

  p_drop_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_n_o |=> !cmd_v_o);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |=> (err_o || (cmd_v_o && cmd_o == ERR_CLR)));

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_v_o |=> !cmd_v_o);

  p_busy_with_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_v_o) |-> !busy_n_o);
endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx #(
  parameter int BYTE_W = 8,
  parameter int BUSY_CYC = 16,
  parameter int SYNC_STAGES = sercmd_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              pol_i,
  input  logic [BYTE_W-1:0] stat_i,
  output logic              sdo_o,
  output logic              cmd_v_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              err_o,
  output logic              busy_n_o
);
  logic cs_n_s, sck_s, sdi_s, pol_s;
  logic byte_v, abort, sdo_d, sdo_oe;
  logic [BYTE_W-1:0] byte_w;

  sercmd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({cs_n_i, sck_i, sdi_i, pol_i}),
    .q_o({cs_n_s, sck_s, sdi_s, pol_s})
  );

  sercmd_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .pol_s(pol_s), .stat_i(stat_i), .byte_v_o(byte_v), .byte_o(byte_w),
    .abort_o(abort), .sdo_d_o(sdo_d), .sdo_oe_o(sdo_oe)
  );

  sercmd_filt #(.BYTE_W(BYTE_W), .BUSY_CYC(BUSY_CYC)) u_filt (
    .clk(clk), .rst(rst), .byte_v_i(byte_v), .byte_i(byte_w),
    .abort_i(abort), .cmd_v_o(cmd_v_o), .cmd_o(cmd_o),
    .err_o(err_o), .busy_n_o(busy_n_o)
  );

  assign sdo_o = sdo_oe ? sdo_d : 1'bz;
endmodule

// File: tb/sercmd_rx_test.sv
module sercmd_rx_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, pol = 1'b0;
  logic [7:0] stat = 8'h00;
  wire sdo;
  logic cmd_v, err, busy_n;
  logic [7:0] cmd;

  sercmd_rx #(.BUSY_CYC(80)) uut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .pol_i(pol), .stat_i(stat), .sdo_o(sdo), .cmd_v_o(cmd_v),
    .cmd_o(cmd), .err_o(err), .busy_n_o(busy_n)
  );

  int total = 0, bad = 0, nstb = 0;
  logic [7:0] last = 8'h00;

  always @(posedge clk) if (!rst && cmd_v) begin nstb++; last = cmd; end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_lo; cs_n = 1'b0; tick(6); endtask
  task automatic cs_hi; cs_n = 1'b1; tick(6); endtask
  task automatic set_pol(input logic p); pol = p; sck = p; tick(6); endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      tick(4);
      rx[i] = sdo;
      sck = ~pol;
      tick(4);
      sck = pol;
    end
    tick(4);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, d);
  endtask

  task automatic t_reset;
    chk("R10 err", {7'd0, err}, 8'h00);
    chk("R10 busy_n", {7'd0, busy_n}, 8'h01);
    chk("R10 strobe", {7'd0, cmd_v}, 8'h00);
    chk("R4 hiz", {7'd0, sdo}, {7'd0, 1'bz});
  endtask

  task automatic t_rise_and_status;
    logic [7:0] rx;
    int n0 = nstb;
    stat = 8'hC6;
    cs_lo;
    xfer(8'hA5, rx);
    chk("R1 byte", last, 8'hA5);
    chk("R2 rising capture count", 8'(nstb - n0), 8'd1);
    chk("R4 status msb first", rx, 8'hC6);
    xfer(8'h00, rx);
    chk("R4 status reload", rx, 8'hC6);
    cs_hi;
    chk("R4 hiz after deselect", {7'd0, sdo}, {7'd0, 1'bz});
    tick(100);
  endtask

  task automatic t_pol_high;
    logic [7:0] rx;
    int n0 = nstb;
    set_pol(1'b1);
    stat = 8'h93;
    cs_lo;
    xfer(8'h5A, rx);
    chk("R2 falling capture byte", last, 8'h5A);
    chk("R2 falling capture count", 8'(nstb - n0), 8'd1);
    chk("R2 status on rising edge", rx, 8'h93);
    cs_hi;
    set_pol(1'b0);
    tick(100);
  endtask

  task automatic t_ignore_desel;
    int n0 = nstb;
    for (int i = 0; i < 8; i++) begin
      sdi = i[0]; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(10);
    chk("R3 ignored while deselected", 8'(nstb - n0), 8'd0);
    cs_lo;
    send(8'h81);
    cs_hi;
    chk("R3 clean byte after idle", last, 8'h81);
    tick(100);
  endtask

  task automatic t_partial;
    int n0 = nstb;
    cs_lo;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    cs_hi;
    cs_lo;
    send(8'h42);
    cs_hi;
    chk("R3 partial discarded byte", last, 8'h42);
    chk("R3 partial discarded count", 8'(nstb - n0), 8'd1);
    tick(100);
  endtask

  task automatic t_busy;
    int n0 = nstb;
    cs_lo;
    send(8'h11);
    tick(2);
    chk("R8 busy low after strobe", {7'd0, busy_n}, 8'h00);
    send(8'h22);
    cs_hi;
    tick(100);
    chk("R8 dropped count", 8'(nstb - n0), 8'd1);
    chk("R8 dropped byte", last, 8'h11);
    chk("R8 busy released", {7'd0, busy_n}, 8'h01);
  endtask

  task automatic t_double;
    int n0;
    cs_lo;
    send(8'h01);
    tick(100);
    n0 = nstb;
    send(8'h6B);
    tick(8);
    chk("R5 first copy no strobe", 8'(nstb - n0), 8'd0);
    send(8'h6B);
    tick(8);
    chk("R7 double mode on count", 8'(nstb - n0), 8'd1);
    chk("R5 matched byte", last, 8'h6B);
    tick(100);
    n0 = nstb;
    send(8'h10);
    send(8'h20);
    tick(8);
    chk("R6 mismatch err", {7'd0, err}, 8'h01);
    chk("R6 mismatch no strobe", 8'(nstb - n0), 8'd0);
    send(8'h33);
    send(8'h33);
    tick(8);
    chk("R6 err sticky", {7'd0, err}, 8'h01);
    chk("R6 other byte accepted", last, 8'h33);
    tick(100);
    send(8'hFF);
    send(8'hFF);
    tick(8);
    chk("R6 err cleared", {7'd0, err}, 8'h00);
    tick(100);
    n0 = nstb;
    send(8'h44);
    cs_hi;
    cs_lo;
    send(8'h44);
    tick(8);
    chk("R9 pending cleared", 8'(nstb - n0), 8'd0);
    send(8'h44);
    tick(8);
    chk("R9 new pair accepted", 8'(nstb - n0), 8'd1);
    tick(100);
    send(8'h00);
    send(8'h00);
    tick(100);
    n0 = nstb;
    send(8'h77);
    tick(8);
    chk("R7 double mode off single byte", 8'(nstb - n0), 8'd1);
    chk("R7 single byte value", last, 8'h77);
    cs_hi;
    tick(100);
  endtask

  bit done = 1'b0;

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset;
    t_rise_and_status;
    t_pol_high;
    t_ignore_desel;
    t_partial;
    t_busy;
    t_double;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule